// File: doc/BRIEF.md
# Byte-wide Stack Push/Pop Sequencer

This block moves a 16-bit register pair to and from a memory that is one byte wide. It owns a 16-bit stack pointer that marks the current top of a stack growing toward lower addresses. It breaks every 16-bit transfer into two single-byte accesses on a simple synchronous memory port. A caller issues one of four commands: push a value, pop a value, load a word from an absolute address, or store a word to an absolute address. The caller then waits for a one-cycle completion pulse.

The four commands share one byte ordering in memory: the less significant byte sits at the lower address. A push stores its high byte first, one below the pointer, and its low byte next, two below the pointer. The pointer moves only after both bytes are written. A pop and an absolute load read the low byte first. An absolute store writes the low byte first. While idle, the stack pointer can be set directly through a dedicated load port.

Top module: `stk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are 0, and `sp` and `rd_data` are 0.
- R2: The command code is 2 bits: 0 push, 1 pop, 2 absolute load, 3 absolute store. A push writes the high byte of `cmd_data` to address sp-1 in the first beat and the low byte to sp-2 in the next cycle.
- R3: A push reduces `sp` by 2, and a pop increases it by 2. `sp` holds its value for the whole time `busy` is high, and the new value is visible in the `done` cycle.
- R4: A pop reads address sp in the first beat and sp+1 in the second, and returns `rd_data` = {byte at sp+1, byte at sp}.
- R5: An absolute load reads `cmd_addr` and then `cmd_addr`+1, and returns {byte at addr+1, byte at addr} on `rd_data`. `sp` is unchanged. `rd_data` changes only on pop or load.
- R6: An absolute store writes the low byte of `cmd_data` to `cmd_addr` and then the high byte to `cmd_addr`+1. `sp` is unchanged.
- R7: A command is accepted on a clock edge where the block is idle and `cmd_valid` is 1. `busy` is then high for exactly 3 cycles: two memory beats and a finish cycle. `done` is high for the one cycle that follows, and a new command may be accepted in that cycle.
- R8: `cmd_valid` is ignored while `busy` is high, and such a command causes no memory access.
- R9: When idle, `sp_load` loads `sp` from `sp_load_val` on the next edge. In that same cycle it takes priority over `cmd_valid`, and the command is dropped. While busy, `sp_load` is ignored.
- R10: All address and stack pointer arithmetic wraps modulo 2^16.
- R11: `mem_we` and `mem_re` are never high together. Each byte access lasts one cycle. Read data is taken from `mem_rdata` in the cycle after the one in which `mem_re` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (0 push, 1 pop, 2 load, 3 store) |
| cmd_addr | input | 16 | Absolute address for load/store |
| cmd_data | input | 16 | Word to push or store |
| sp_load | input | 1 | Direct stack pointer write request |
| sp_load_val | input | 16 | Value for the direct stack pointer write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word returned by the last pop or load |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after the read strobe |

## Verification
The bench checks the beat order of push against pop. A design that writes the low byte first on push, or moves the pointer before the second byte, lands the bytes at the wrong addresses, and the next pop or absolute load then returns a swapped or foreign word. It pushes across address 0 and stores at 0xFFFF. A design whose pointer arithmetic carries into a 17th bit, or fails to wrap, then touches the wrong byte. It issues commands and pointer loads while busy, and a pointer load together with a command. A design that accepts either of these corrupts memory or the pointer, and later loads expose it. Commands are issued back to back in the completion cycle, which catches a design that is still busy when `done` is high.

// File: rtl/stk_pkg.sv
// Package: shared command and sequencing types for the stack sequencer.
// Assumes a two-bit command code, fixed by the block's port contract.
package stk_pkg;
    typedef enum logic [1:0] {
        OP_PUSH  = 2'd0,
        OP_POP   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STORE = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_FIN   = 2'd3
    } stk_state_e;
endpackage

// File: rtl/stk_ctrl.sv
// Module: sequencing control. Accepts one command when idle, steps through
// two memory beats and a finish cycle, and raises done for one cycle after.
// Assumes a pointer load request in the idle cycle wins over a command.
module stk_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  stk_op_e    cmd_op,
    input  logic       sp_load,
    output stk_state_e state,
    output stk_op_e    op_q,
    output logic       accept,
    output logic       done
);
    stk_state_e state_q;

    // Command is taken only when idle and no pointer load competes.
    assign accept = (state_q == ST_IDLE) && cmd_valid && !sp_load;
    assign state  = state_q;

    // Advance the fixed three-step sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) state_q <= ST_BEAT0;
                ST_BEAT0: state_q <= ST_BEAT1;
                ST_BEAT1: state_q <= ST_FIN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the accepted command code for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= OP_PUSH;
        else if (accept) op_q <= cmd_op;
    end

    // Completion pulse in the cycle after the finish step.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state_q == ST_FIN);
    end
endmodule

// File: rtl/stk_addr.sv
// Module: stack pointer register and byte address generator. Push walks
// downward from the pointer, every other command walks upward from its base.
// Assumes the pointer does not change during a command (loads only when idle).
module stk_addr
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  stk_op_e           cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  stk_state_e        state,
    input  stk_op_e           op_q,
    input  logic              sp_load,
    input  logic [ADDR_W-1:0] sp_load_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] base_q;

    assign sp = sp_q;

    // Capture the start address: the pointer for stack commands, else the operand.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (accept)
            base_q <= (cmd_op == OP_PUSH || cmd_op == OP_POP) ? sp_q : cmd_addr;
    end

    // Per-beat byte address with modulo wrap from the fixed width.
    always_comb begin
        mem_addr = '0;
        case (state)
            ST_BEAT0: mem_addr = (op_q == OP_PUSH) ? base_q - ONE : base_q;
            ST_BEAT1: mem_addr = (op_q == OP_PUSH) ? base_q - TWO : base_q + ONE;
            default:  mem_addr = '0;
        endcase
    end

    // Pointer: direct load when idle, adjust by two at the finish step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (state == ST_IDLE && sp_load) begin
            sp_q <= sp_load_val;
        end else if (state == ST_FIN) begin
            if (op_q == OP_PUSH)     sp_q <= sp_q - TWO;
            else if (op_q == OP_POP) sp_q <= sp_q + TWO;
        end
    end
endmodule

// File: rtl/stk_data.sv
// Module: byte lane steering. Splits the word for writes (high byte first on
// push, low byte first on store) and assembles read bytes into a word.
// Assumes read data arrives one cycle after the read strobe.
module stk_data
    import stk_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [2*BYTE_W-1:0] cmd_data,
    input  stk_state_e          state,
    input  stk_op_e             op_q,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    output logic [2*BYTE_W-1:0] rd_data
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] wdata_q;
    logic [BYTE_W-1:0] lo_q;
    logic [WORD_W-1:0] rd_q;
    logic              in_beat;
    logic              is_read;
    logic              hi_lane;

    assign in_beat = (state == ST_BEAT0) || (state == ST_BEAT1);
    assign is_read = (op_q == OP_POP) || (op_q == OP_LOAD);
    // High byte goes in beat 0 for push, in beat 1 for store.
    assign hi_lane = ((state == ST_BEAT0) == (op_q == OP_PUSH));

    assign mem_we    = in_beat && !is_read;
    assign mem_re    = in_beat && is_read;
    assign mem_wdata = mem_we ? (hi_lane ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0])
                              : '0;
    assign rd_data   = rd_q;

    // Hold the outgoing word for the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)      wdata_q <= '0;
        else if (accept) wdata_q <= cmd_data;
    end

    // Take the first (low) read byte as it returns during beat 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lo_q <= '0;
        else if (state == ST_BEAT1) lo_q <= mem_rdata;
    end

    // Assemble the word when the second (high) byte returns at the finish step.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_q <= '0;
        else if (state == ST_FIN && is_read) rd_q <= {mem_rdata, lo_q};
    end
endmodule

// File: rtl/stk_seq.sv
// Module: top of the byte-wide stack sequencer. Ties control, address and
// data units together. Assumes a single-cycle synchronous byte memory with
// no wait states and no arbitration.
module stk_seq
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [2*BYTE_W-1:0] cmd_data,
    input  logic                sp_load,
    input  logic [ADDR_W-1:0]   sp_load_val,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0]   sp,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    stk_state_e state;
    stk_op_e    op_q;
    stk_op_e    cmd_op_e;
    logic       accept;

    assign cmd_op_e = stk_op_e'(cmd_op);
    assign busy     = (state != ST_IDLE);

    stk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op_e),
        .sp_load   (sp_load),
        .state     (state),
        .op_q      (op_q),
        .accept    (accept),
        .done      (done)
    );

    stk_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .cmd_op      (cmd_op_e),
        .cmd_addr    (cmd_addr),
        .state       (state),
        .op_q        (op_q),
        .sp_load     (sp_load),
        .sp_load_val (sp_load_val),
        .mem_addr    (mem_addr),
        .sp          (sp)
    );

    stk_data #(.BYTE_W(BYTE_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_data  (cmd_data),
        .state     (state),
        .op_q      (op_q),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/stk_seq_chk.sv
// Module: protocol checker for the stack sequencer, bound to the top.
// Assumes the held command code is visible through the bind.
module stk_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              sp_load,
    input logic [ADDR_W-1:0] sp_load_val,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] sp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [1:0]        op_q
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !sp_load) |=> busy); // R7

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sp)); // R3

    AST_PUSH_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && op_q == 2'd0)
            |-> mem_addr == ADDR_W'($past(mem_addr) - ADDR_W'(1))); // R2

    AST_READ_ASC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re))
            |-> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))); // R4

    AST_STORE_ASC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && op_q == 2'd3)
            |-> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))); // R6

    AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp_load) |=> sp == $past(sp_load_val)); // R9
endmodule

bind stk_seq stk_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val),
    .busy        (busy),
    .done        (done),
    .sp          (sp),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .op_q        (op_q)
);

// File: tb/test_stk_seq.sv
module test_stk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [15:0] cmd_data = 16'h0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = 16'h0;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] rd_data, sp, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stk_seq i_stk_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sp_load(sp_load),
        .sp_load_val(sp_load_val), .busy(busy), .done(done), .rd_data(rd_data),
        .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Sparse byte stores: one seen by the design, one kept by the model.
    logic [7:0] dut_mem [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] get_dut(logic [15:0] a);
        return dut_mem.exists(int'(a)) ? dut_mem[int'(a)] : 8'h00;
    endfunction
    function automatic logic [7:0] get_ref(logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    // Memory attached to the design: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) dut_mem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= get_dut(mem_addr);
    end

    // Behavioural reference model.
    int          m_ph = 0;
    logic [1:0]  m_op = 2'd0;
    logic [15:0] m_sp = 16'h0, m_base = 16'h0, m_data = 16'h0, m_rd = 16'h0;
    bit          m_done = 1'b0;

    always @(posedge clk) begin
        logic [15:0] t;
        if (!rst_n) begin
            m_ph = 0; m_sp = 16'h0; m_rd = 16'h0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            case (m_ph)
                0: begin
                    if (sp_load) m_sp = sp_load_val;
                    else if (cmd_valid) begin
                        m_op = cmd_op; m_data = cmd_data;
                        m_base = (cmd_op < 2'd2) ? m_sp : cmd_addr;
                        m_ph = 1;
                    end
                end
                1: m_ph = 2;
                2: m_ph = 3;
                default: begin
                    case (m_op)
                        2'd0: begin
                            t = m_sp - 16'd1; ref_mem[int'(t)] = m_data[15:8];
                            t = m_sp - 16'd2; ref_mem[int'(t)] = m_data[7:0];
                            m_sp = t;
                        end
                        2'd1: begin
                            t = m_sp + 16'd1;
                            m_rd = {get_ref(t), get_ref(m_sp)};
                            m_sp = m_sp + 16'd2;
                        end
                        2'd2: begin
                            t = m_base + 16'd1;
                            m_rd = {get_ref(t), get_ref(m_base)};
                        end
                        default: begin
                            ref_mem[int'(m_base)] = m_data[7:0];
                            t = m_base + 16'd1; ref_mem[int'(t)] = m_data[15:8];
                        end
                    endcase
                    m_ph = 0; m_done = 1'b1;
                end
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design with the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit b0, b1, ewe, ere;
            logic [15:0] ea;
            logic [7:0]  ewd;
            b0  = (m_ph == 1); b1 = (m_ph == 2);
            ewe = (b0 || b1) && (m_op == 2'd0 || m_op == 2'd3);
            ere = (b0 || b1) && (m_op == 2'd1 || m_op == 2'd2);
            if (m_op == 2'd0) ea = b0 ? m_base - 16'd1 : m_base - 16'd2;
            else              ea = b0 ? m_base : m_base + 16'd1;
            if (m_op == 2'd0) ewd = b0 ? m_data[15:8] : m_data[7:0];
            else              ewd = b0 ? m_data[7:0] : m_data[15:8];
            chk("R7 busy", 32'(busy), 32'(m_ph != 0));
            chk("R7 done", 32'(done), 32'(m_done));
            chk("R3 sp", 32'(sp), 32'(m_sp));
            chk("R5 rd_data", 32'(rd_data), 32'(m_rd));
            chk("R11 mem_we", 32'(mem_we), 32'(ewe));
            chk("R11 mem_re", 32'(mem_re), 32'(ere));
            if (ewe || ere) chk("R2 mem_addr", 32'(mem_addr), 32'(ea));
            if (ewe)        chk("R2 mem_wdata", 32'(mem_wdata), 32'(ewd));
        end
    end

    // Issue a command; returns at the negedge of its done cycle.
    task automatic issue(logic [1:0] op, logic [15:0] a, logic [15:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_sp(logic [15:0] v);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    task automatic poke(logic [15:0] a, logic [7:0] v);
        dut_mem[int'(a)] = v;
        ref_mem[int'(a)] = v;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1 sp", 32'(sp), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 strobes", 32'({mem_we, mem_re}), 32'h0);
        chk("R1 rd_data", 32'(rd_data), 32'h0);

        load_sp(16'h8000);
        chk("R9 sp load", 32'(sp), 32'h8000);

        issue(2'd0, 16'h0, 16'h1234);
        chk("R3 push sp", 32'(sp), 32'h7FFE);
        chk("R7 done after push", 32'(done), 32'h1);
        issue(2'd0, 16'h0, 16'hABCD);           // back to back with done cycle
        chk("R3 second push sp", 32'(sp), 32'h7FFC);
        issue(2'd1, 16'h0, 16'h0);
        chk("R4 pop value", 32'(rd_data), 32'hABCD);
        chk("R4 pop sp", 32'(sp), 32'h7FFE);
        issue(2'd2, 16'h7FFC, 16'h0);
        chk("R5 load value", 32'(rd_data), 32'hABCD);
        chk("R5 load keeps sp", 32'(sp), 32'h7FFE);

        issue(2'd3, 16'h4000, 16'hBEEF);
        chk("R6 store keeps sp", 32'(sp), 32'h7FFE);
        chk("R5 store keeps rd_data", 32'(rd_data), 32'hABCD);
        issue(2'd2, 16'h4000, 16'h0);
        chk("R6 store order", 32'(rd_data), 32'hBEEF);
        issue(2'd2, 16'h3FFF, 16'h0);
        chk("R6 low byte at base", 32'(rd_data), 32'hEF00);

        // R8/R9: command and pointer load while busy are ignored
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h0F0F;
        @(negedge clk);
        cmd_op = 2'd3; cmd_addr = 16'h5000; cmd_data = 16'h7777;
        sp_load = 1'b1; sp_load_val = 16'h1111;
        @(negedge clk);
        cmd_valid = 1'b0; sp_load = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 load while busy ignored", 32'(sp), 32'h7FFC);
        issue(2'd2, 16'h5000, 16'h0);
        chk("R8 busy command ignored", 32'(rd_data), 32'h0000);

        // R9: pointer load wins over a simultaneous command
        sp_load = 1'b1; sp_load_val = 16'h2000;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h3333;
        @(negedge clk);
        sp_load = 1'b0; cmd_valid = 1'b0;
        chk("R9 command dropped", 32'(busy), 32'h0);
        chk("R9 priority sp", 32'(sp), 32'h2000);
        @(negedge clk);

        // R4: pop from preset memory
        poke(16'h9000, 8'h11); poke(16'h9001, 8'h22);
        load_sp(16'h9000);
        issue(2'd1, 16'h0, 16'h0);
        chk("R4 preset pop", 32'(rd_data), 32'h2211);
        chk("R4 preset sp", 32'(sp), 32'h9002);

        // R10: wrap around address zero
        load_sp(16'h0001);
        issue(2'd0, 16'h0, 16'h5566);
        chk("R10 push wrap sp", 32'(sp), 32'hFFFF);
        issue(2'd2, 16'hFFFF, 16'h0);
        chk("R10 load wrap", 32'(rd_data), 32'h5566);
        issue(2'd1, 16'h0, 16'h0);
        chk("R10 pop wrap value", 32'(rd_data), 32'h5566);
        chk("R10 pop wrap sp", 32'(sp), 32'h0001);
        issue(2'd3, 16'hFFFF, 16'hA55A);
        issue(2'd2, 16'hFFFF, 16'h0);
        chk("R10 store wrap", 32'(rd_data), 32'hA55A);
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule